// File: doc/BRIEF.md
# Real-Mode Address Gate

This block turns a 16-bit segment and a 16-bit offset into a physical address in the legacy real-mode way. The segment is shifted left by four bits and the offset is added to it. The largest result is 0x10FFEF, which lies just above the 1 MiB boundary. One control bit, the wrap gate, decides what happens to address line 20. While the gate is off, line 20 is held at zero, so any address from 0x100000 to 0x10FFEF folds back onto the bottom 64 KiB of memory. While the gate is on, the full sum reaches memory above 1 MiB.

The gate bit is held in an 8-bit control register on a simple I/O bus. Software turns the gate on by reading the register, setting bit 1 in the value it read, and writing that value back. Every write stores all eight bits exactly as written, and a read returns the stored value, so this sequence leaves the other seven bits unchanged. The address path is purely combinational. It uses the gate value that is registered at the moment, so a register write changes the addresses only from the next clock cycle on.

Top module: `rm_addr_gate`

## Requirements
- R1: With the gate on, `phys_addr_o` equals `seg_i`*16 + `off_i`, and bits 23..21 are zero.
- R2: With the gate off, `phys_addr_o` equals (`seg_i`*16 + `off_i`) modulo 2^20, so bit 20 is zero.
- R3: While `rst_n` is low and after reset, the control register holds 0x00 and the gate is off.
- R4: A cycle with `io_wr_i`=1 and `io_addr_i`=0x0092 loads all 8 bits of `io_wdata_i` into the control register at that clock edge.
- R5: While `io_rd_i`=1 and `io_addr_i`=0x0092, `io_rdata_o` shows the control register value in the same cycle; at any other time it shows 0x00.
- R6: A write at any address other than 0x0092 leaves the control register unchanged.
- R7: A write changes `phys_addr_o` only from the cycle after the write; during the write cycle the old gate value still applies.
- R8: The gate is bit 1 of the control register (1 = gate on). The other seven bits have no effect on the address.
- R9: Segment 0xFFFF with offset 0xFFFF gives 0x10FFEF with the gate on and 0x00FFEF with the gate off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_i | input | 16 | Real-mode segment value |
| off_i | input | 16 | Real-mode offset value |
| phys_addr_o | output | 24 | Physical address after the gate is applied |
| io_addr_i | input | 16 | I/O bus address |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data |

## Verification
The bench targets the fold at the 1 MiB boundary: inputs 0xFFFF:0xFFFF and sums just above 0x100000, with the gate both off and on. A design that masked the wrong bit, or that dropped the carry out of the adder, would give a wrong address in one of those two cases.

It checks the address during the same cycle as the port write. A design that forwarded the write data straight to the address path would enable the gate one cycle early.

It writes values that set bit 1 together with other bits, and values that clear bit 1 while setting the others. Reading these back exposes a register that keeps only the gate bit, and a design that decoded the gate from the wrong bit. It also writes to the neighbouring address 0x0093 to catch a decoder that ignores the low address bit.

// File: rtl/ragu_pkg.sv
// Package: shared constants for the real-mode address gate.
// Assumes: the legacy 16-bit segment/offset format and a 24-bit physical bus.
package ragu_pkg;
    localparam int unsigned SEG_W_D    = 16;
    localparam int unsigned OFF_W_D    = 16;
    localparam int unsigned SHIFT_D    = 4;
    localparam int unsigned PA_W_D     = 24;
    localparam int unsigned WRAP_BIT_D = 20;
    localparam int unsigned IO_AW_D    = 16;
    localparam int unsigned DW_D       = 8;
    localparam int unsigned GATE_POS_D = 1;
    localparam logic [15:0] PORT_ADDR_D = 16'h0092;
endpackage

// File: rtl/ragu_addr_former.sv
// Module: forms the linear real-mode sum segment*2^SHIFT + offset, zero-extended.
// Assumes: PA_W is wide enough to hold the full sum including its carry.
module ragu_addr_former #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    parameter int unsigned PA_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PA_W-1:0]  lin_o
);
    localparam int unsigned TOP_W = ((SEG_W + SHIFT) > OFF_W) ? (SEG_W + SHIFT) : OFF_W;
    localparam int unsigned SUM_W = TOP_W + 1;
    localparam logic [SUM_W-1:0] MAX_SUM =
        (SUM_W'({SEG_W{1'b1}}) << SHIFT) + SUM_W'({OFF_W{1'b1}});

    logic [SUM_W-1:0] seg_ext;
    logic [SUM_W-1:0] off_ext;
    logic [SUM_W-1:0] sum_w;

    // Align the segment, extend the offset and add them together.
    always_comb begin
        seg_ext = SUM_W'(seg_i) << SHIFT;
        off_ext = SUM_W'(off_i);
        sum_w   = seg_ext + off_ext;
        lin_o   = PA_W'(sum_w);
    end

    // R9
    sum_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lin_o <= PA_W'(MAX_SUM));
endmodule

// File: rtl/ragu_gate_mask.sv
// Module: applies the wrap gate to the linear address; clears WRAP_BIT when the gate is off.
// Assumes: WRAP_BIT < PA_W; the other bits pass through unchanged.
module ragu_gate_mask #(
    parameter int unsigned PA_W     = 24,
    parameter int unsigned WRAP_BIT = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PA_W-1:0] lin_i,
    input  logic            gate_i,
    output logic [PA_W-1:0] pa_o
);
    // One lane for each address bit; only the wrap lane is gated.
    for (genvar b = 0; b < PA_W; b++) begin : g_lane
        if (b == WRAP_BIT) begin : g_wrap
            assign pa_o[b] = lin_i[b] & gate_i;
        end else begin : g_pass
            assign pa_o[b] = lin_i[b];
        end
    end

    // R2
    wrap_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |-> (pa_o[WRAP_BIT] == 1'b0));
    // R1
    gate_open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_i |-> (pa_o == lin_i));
endmodule

// File: rtl/ragu_ctl_port.sv
// Module: the control register on the I/O bus, read and written as a whole byte.
// Assumes: single-cycle strobes; the read data is combinational and zero when not selected.
module ragu_ctl_port #(
    parameter int unsigned    IO_AW     = 16,
    parameter int unsigned    DW        = 8,
    parameter int unsigned    GATE_POS  = 1,
    parameter logic [IO_AW-1:0] PORT_ADDR = 16'h0092
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] io_addr_i,
    input  logic             io_rd_i,
    input  logic             io_wr_i,
    input  logic [DW-1:0]    io_wdata_i,
    output logic [DW-1:0]    io_rdata_o,
    output logic             gate_o
);
    logic          hit;
    logic [DW-1:0] ctl_q;

    // Address decode for the single port.
    assign hit = (io_addr_i == PORT_ADDR);

    // Control register: cleared by reset, fully overwritten by a selected write.
    always_ff @(posedge clk) begin
        if (!rst_n)                ctl_q <= '0;
        else if (io_wr_i && hit)   ctl_q <= io_wdata_i;
    end

    // Read path: show the register while selected, zero otherwise.
    always_comb begin
        io_rdata_o = (io_rd_i && hit) ? ctl_q : '0;
    end

    assign gate_o = ctl_q[GATE_POS];

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(io_wr_i) && $past(hit)) |-> (ctl_q == $past(io_wdata_i)));
    // R6
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr_i && hit) |=> $stable(ctl_q));
    // R5
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd_i && hit) |-> (io_rdata_o == '0));
endmodule

// File: rtl/rm_addr_gate.sv
// Module: top of the real-mode address gate. It joins the adder, the gate mask and the control port.
// Assumes: a synchronous active-low reset; the address output is combinational from the inputs and the stored gate bit.
module rm_addr_gate
    import ragu_pkg::*;
#(
    parameter int unsigned      SEG_W     = SEG_W_D,
    parameter int unsigned      OFF_W     = OFF_W_D,
    parameter int unsigned      SHIFT     = SHIFT_D,
    parameter int unsigned      PA_W      = PA_W_D,
    parameter int unsigned      WRAP_BIT  = WRAP_BIT_D,
    parameter int unsigned      IO_AW     = IO_AW_D,
    parameter int unsigned      DW        = DW_D,
    parameter int unsigned      GATE_POS  = GATE_POS_D,
    parameter logic [IO_AW-1:0] PORT_ADDR = PORT_ADDR_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PA_W-1:0]  phys_addr_o,
    input  logic [IO_AW-1:0] io_addr_i,
    input  logic             io_rd_i,
    input  logic             io_wr_i,
    input  logic [DW-1:0]    io_wdata_i,
    output logic [DW-1:0]    io_rdata_o
);
    logic [PA_W-1:0] lin_w;
    logic            gate_w;

    ragu_addr_former #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)
    ) former_i (
        .clk(clk), .rst_n(rst_n), .seg_i(seg_i), .off_i(off_i), .lin_o(lin_w)
    );

    ragu_ctl_port #(
        .IO_AW(IO_AW), .DW(DW), .GATE_POS(GATE_POS), .PORT_ADDR(PORT_ADDR)
    ) port_i (
        .clk(clk), .rst_n(rst_n), .io_addr_i(io_addr_i), .io_rd_i(io_rd_i),
        .io_wr_i(io_wr_i), .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o),
        .gate_o(gate_w)
    );

    ragu_gate_mask #(
        .PA_W(PA_W), .WRAP_BIT(WRAP_BIT)
    ) mask_i (
        .clk(clk), .rst_n(rst_n), .lin_i(lin_w), .gate_i(gate_w), .pa_o(phys_addr_o)
    );

    // R7
    gate_change_delayed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_i && (io_addr_i == PORT_ADDR) && !gate_w) |-> (phys_addr_o[WRAP_BIT] == 1'b0));
endmodule

// File: tb/rm_addr_gate_tb_top.sv
// Bench: reference model of the block with a check in every cycle. The gate register is modelled as an integer.
module rm_addr_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] seg = '0, off = '0, ioa = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wd = '0;
    logic [23:0] pa;
    logic [7:0]  rdata;
    int          checks = 0, failures = 0;
    int          ref_reg = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    rm_addr_gate dut_i (
        .clk(clk), .rst_n(rst_n), .seg_i(seg), .off_i(off), .phys_addr_o(pa),
        .io_addr_i(ioa), .io_rd_i(rd), .io_wr_i(wr), .io_wdata_i(wd), .io_rdata_o(rdata)
    );

    // Drive one cycle, compare mid-cycle against the model, then step the model at the edge.
    task automatic step(input logic [15:0] s, input logic [15:0] o, input logic [15:0] a,
                        input logic r, input logic w, input logic [7:0] d, input string tag);
        int sum, exp_pa, exp_rd;
        seg = s; off = o; ioa = a; rd = r; wr = w; wd = d;
        #1.5;
        sum    = s * 16 + o;
        exp_pa = ((ref_reg >> 1) & 1) ? sum : (sum % (1 << 20));
        exp_rd = (r && a == 16'h0092) ? ref_reg : 0;
        checks++;
        if (pa !== exp_pa[23:0]) begin
            failures++;
            $display("FAIL %s addr: got %h expected %h", tag, pa, exp_pa[23:0]);
        end
        checks++;
        if (rdata !== exp_rd[7:0]) begin
            failures++;
            $display("FAIL %s rdata: got %h expected %h", tag, rdata, exp_rd[7:0]);
        end
        @(posedge clk);
        if (!rst_n) ref_reg = 0;
        else if (w && a == 16'h0092) ref_reg = d;
        #1;
    endtask

    initial begin
        logic [7:0] v;
        @(posedge clk); #1;
        step(16'hFFFF, 16'hFFFF, 16'h0092, 1, 0, 0, "R3");
        step(16'h1234, 16'h0010, 16'h0092, 1, 1, 8'hFF, "R3");
        rst_n = 1'b1;
        step(16'hFFFF, 16'hFFFF, 16'h0092, 1, 0, 0, "R9");
        step(16'hF000, 16'h0000, 16'h0000, 0, 0, 0, "R2");
        step(16'hFFFF, 16'h0010, 16'h0000, 0, 0, 0, "R2");
        // read-modify-write that turns the gate on
        step(16'hFFFF, 16'h0010, 16'h0092, 1, 0, 0, "R5");
        v = rdata | 8'h02;
        step(16'hFFFF, 16'h0010, 16'h0092, 0, 1, v, "R7");
        step(16'hFFFF, 16'h0010, 16'h0000, 0, 0, 0, "R1");
        step(16'hFFFF, 16'hFFFF, 16'h0092, 1, 0, 0, "R9");
        // bit 1 cleared, all other bits set
        step(16'hFFFF, 16'hFFFF, 16'h0092, 0, 1, 8'hFD, "R4");
        step(16'hFFFF, 16'hFFFF, 16'h0092, 1, 0, 0, "R8");
        // a write to the neighbouring address must be ignored
        step(16'hFFFF, 16'hFFFF, 16'h0093, 0, 1, 8'h02, "R6");
        step(16'hFFFF, 16'hFFFF, 16'h0093, 1, 0, 0, "R6");
        step(16'hFFFF, 16'hFFFF, 16'h0092, 1, 0, 0, "R6");
        step(16'h0000, 16'h0000, 16'h0092, 0, 1, 8'h5A, "R4");
        step(16'hFFFF, 16'h0020, 16'h0092, 1, 0, 0, "R8");
        for (int i = 0; i < 400; i++) begin
            logic [15:0] ra;
            ra = ($urandom % 4 == 0) ? 16'h0092 : 16'(16'h0090 + $urandom % 4);
            step(16'($urandom), 16'($urandom), ra, 1'($urandom), 1'($urandom % 3 == 0),
                 8'($urandom), "R1");
        end
        done = 1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 5000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule